// File: doc/BRIEF.md
# Zero-Test Branch Next-PC Unit

This block works out the program counter for the next instruction on a machine whose instructions are all 8 bytes long. Each cycle it can accept one instruction word along with the current PC, a 32-bit source operand and a 64-bit register-supplied target. It recognises two branch forms. The first is a direct branch whose signed immediate counts whole instructions relative to the instruction that follows. The second is an indirect branch that jumps to the register target. Both forms test the source operand against zero, and one modifier bit in the instruction inverts the sense of that test. Any other instruction simply advances the PC by one instruction.

The block also decodes the per-instruction action field. It flags the reconverge action so that divergence-handling logic further on knows the active mask may change. It treats the return action as a stop: a halt output rises and the PC freezes. A taken indirect target that is not on an 8-byte boundary is rounded down to one, and a fault flag reports it. All outputs are registered and change only on an accepted instruction.

Top module: `zbr_pc_unit`

## Requirements
- R1: While reset is asserted and after its release, next_pc_o equals the RESET_VEC parameter (default 0x1000), and taken_o, reconv_o, halt_o and align_fault_o are 0.
- R2: An accepted instruction whose opcode (bits [7:0]) is neither 0x1F nor 0x2F sets next_pc_o to cur_pc_i + 8 and taken_o to 0 one cycle later.
- R3: Opcode 0x1F is the direct branch. Its offset is bits [34:8], sign-extended from 27 bits. When taken, next_pc_o becomes cur_pc_i + 8*(offset + 1) and taken_o becomes 1.
- R4: Bit 36 sets the test polarity for both branch forms. When the bit is 0, the branch is taken if src_i is nonzero. When the bit is 1, the branch is taken if src_i is zero. A branch that is not taken gives cur_pc_i + 8 with taken_o = 0.
- R5: Opcode 0x2F is the indirect branch. When taken, next_pc_o becomes ind_tgt_i with bits [2:0] cleared.
- R6: align_fault_o is 1 exactly when the accepted instruction was a taken indirect branch whose ind_tgt_i[2:0] is nonzero. Otherwise it is 0.
- R7: The action field is bits [61:59]. Code 2 (reconverge) sets reconv_o to 1, and any other code sets it to 0.
- R8: Action code 7 (return) sets halt_o to 1, next_pc_o to cur_pc_i and taken_o to 0, whatever the opcode. After that, valid_i is ignored and every output holds until reset.
- R9: When valid_i is 0, all outputs keep their values, whatever the other inputs are.
- R10: Action codes 0 (wait on all slots), 1 (barrier) and 5 (terminate discarded threads) do not change the next-PC result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| cur_pc_i | input | 64 | Address of the presented instruction |
| insn_i | input | 64 | Instruction word |
| src_i | input | 32 | Operand tested against zero |
| ind_tgt_i | input | 64 | Register-supplied target for the indirect branch |
| next_pc_o | output | 64 | Registered next program counter |
| taken_o | output | 1 | Last accepted instruction was a taken branch |
| reconv_o | output | 1 | Last accepted instruction carried the reconverge action |
| halt_o | output | 1 | Return action seen; PC frozen |
| align_fault_o | output | 1 | Taken indirect target was misaligned and rounded down |

## Verification
The bench drives offsets at both extremes of the 27-bit field, zero and small negative values. A design that dropped the sign extension or the "+1" relative to the following instruction would land on the wrong instruction. It runs every combination of polarity bit and zero or nonzero source for both branch forms, so an inverted or ignored polarity bit shows up as a wrong taken flag. Misaligned indirect targets are sent both when the branch is taken and when it is not, to catch a fault raised on not-taken branches or a target that is not rounded down. The return case sends a branch after the halt, because a design that failed to freeze would move the PC again.

// File: rtl/zbr_pkg.sv
`timescale 1ns/1ps
package zbr_pkg;

  localparam int ACT_W = 3;

  localparam logic [ACT_W-1:0] ACT_WAIT_ALL = 3'd0;
  localparam logic [ACT_W-1:0] ACT_SYNC     = 3'd1;
  localparam logic [ACT_W-1:0] ACT_RECONV   = 3'd2;
  localparam logic [ACT_W-1:0] ACT_KILL_HLP = 3'd5;
  localparam logic [ACT_W-1:0] ACT_RETURN   = 3'd7;

  typedef enum logic [1:0] {
    KIND_SEQ      = 2'd0,
    KIND_DIRECT   = 2'd1,
    KIND_INDIRECT = 2'd2
  } kind_e;

endpackage

// File: rtl/zbr_decode.sv
`timescale 1ns/1ps
module zbr_decode
  import zbr_pkg::*;
#(
  parameter int INSN_W  = 64,
  parameter int OPC_W   = 8,
  parameter int OFF_LSB = 8,
  parameter int OFF_W   = 27,
  parameter int POL_BIT = 36,
  parameter int ACT_LSB = 59,
  parameter logic [OPC_W-1:0] OPC_DIRECT   = 8'h1F,
  parameter logic [OPC_W-1:0] OPC_INDIRECT = 8'h2F
) (
  input  logic [INSN_W-1:0] insn_i,
  output kind_e             kind_o,
  output logic              pol_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              reconv_o,
  output logic              ret_o
);

  logic [OPC_W-1:0] opc;
  logic [ACT_W-1:0] act;
  logic             unused_insn_bits;

  assign opc      = insn_i[OPC_W-1:0];
  assign act      = insn_i[ACT_LSB +: ACT_W];
  assign offset_o = insn_i[OFF_LSB +: OFF_W];
  assign pol_o    = insn_i[POL_BIT];

  always_comb begin
    kind_o = KIND_SEQ;
    if (opc == OPC_DIRECT) begin
      kind_o = KIND_DIRECT;
    end else if (opc == OPC_INDIRECT) begin
      kind_o = KIND_INDIRECT;
    end
  end

  assign reconv_o = (act == ACT_RECONV);
  assign ret_o    = (act == ACT_RETURN);

  assign unused_insn_bits = ^insn_i;

endmodule

// File: rtl/zbr_target.sv
`timescale 1ns/1ps
module zbr_target
  import zbr_pkg::*;
#(
  parameter int PC_W       = 64,
  parameter int SRC_W      = 32,
  parameter int OFF_W      = 27,
  parameter int ALIGN_BITS = 3
) (
  input  logic [PC_W-1:0]  cur_pc_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [PC_W-1:0]  ind_tgt_i,
  input  kind_e            kind_i,
  input  logic             pol_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [PC_W-1:0]  nxt_pc_o,
  output logic             taken_o,
  output logic             misalign_o
);

  localparam int INSN_BYTES = 1 << ALIGN_BITS;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] step;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] direct_pc;
  logic [PC_W-1:0] indirect_pc;
  logic            src_zero;
  logic            cond;

  generate
    if (OFF_W < PC_W) begin : g_sext
      assign off_ext = {{(PC_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
    end else begin : g_trunc
      assign off_ext = offset_i[PC_W-1:0];
    end
  endgenerate

  assign step        = (off_ext + PC_W'(1)) << ALIGN_BITS;
  assign seq_pc      = cur_pc_i + PC_W'(INSN_BYTES);
  assign direct_pc   = cur_pc_i + step;
  assign indirect_pc = {ind_tgt_i[PC_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  assign src_zero = ~|src_i;
  assign cond     = pol_i ? src_zero : ~src_zero;

  always_comb begin
    nxt_pc_o   = seq_pc;
    taken_o    = 1'b0;
    misalign_o = 1'b0;
    unique case (kind_i)
      KIND_DIRECT: begin
        if (cond) begin
          nxt_pc_o = direct_pc;
          taken_o  = 1'b1;
        end
      end
      KIND_INDIRECT: begin
        if (cond) begin
          nxt_pc_o   = indirect_pc;
          taken_o    = 1'b1;
          misalign_o = |ind_tgt_i[ALIGN_BITS-1:0];
        end
      end
      default: begin
        nxt_pc_o = seq_pc;
      end
    endcase
  end

endmodule

// File: rtl/zbr_pc_reg.sv
`timescale 1ns/1ps
module zbr_pc_reg #(
  parameter int              PC_W      = 64,
  parameter logic [PC_W-1:0] RESET_VEC = 64'h1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [PC_W-1:0] cur_pc_i,
  input  logic [PC_W-1:0] nxt_pc_i,
  input  logic            taken_i,
  input  logic            misalign_i,
  input  logic            reconv_i,
  input  logic            ret_i,
  output logic [PC_W-1:0] pc_o,
  output logic            taken_o,
  output logic            reconv_o,
  output logic            halt_o,
  output logic            fault_o
);

  logic [PC_W-1:0] pc_q,     pc_d;
  logic            taken_q,  taken_d;
  logic            reconv_q, reconv_d;
  logic            halt_q,   halt_d;
  logic            fault_q,  fault_d;
  logic            upd_en;

  assign upd_en = valid_i & ~halt_q;

  always_comb begin
    if (ret_i) begin
      pc_d    = cur_pc_i;
      taken_d = 1'b0;
      fault_d = 1'b0;
    end else begin
      pc_d    = nxt_pc_i;
      taken_d = taken_i;
      fault_d = misalign_i;
    end
    reconv_d = reconv_i;
    halt_d   = ret_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_VEC;
      taken_q  <= 1'b0;
      reconv_q <= 1'b0;
      halt_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else if (upd_en) begin
      pc_q     <= pc_d;
      taken_q  <= taken_d;
      reconv_q <= reconv_d;
      halt_q   <= halt_d;
      fault_q  <= fault_d;
    end
  end

  assign pc_o     = pc_q;
  assign taken_o  = taken_q;
  assign reconv_o = reconv_q;
  assign halt_o   = halt_q;
  assign fault_o  = fault_q;

endmodule

// File: rtl/zbr_pc_unit.sv
`timescale 1ns/1ps
module zbr_pc_unit
  import zbr_pkg::*;
#(
  parameter int              PC_W      = 64,
  parameter int              INSN_W    = 64,
  parameter int              SRC_W     = 32,
  parameter int              OFF_W     = 27,
  parameter logic [PC_W-1:0] RESET_VEC = 64'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [PC_W-1:0]   cur_pc_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [PC_W-1:0]   ind_tgt_i,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              reconv_o,
  output logic              halt_o,
  output logic              align_fault_o
);

  kind_e            kind;
  logic             pol;
  logic [OFF_W-1:0] offset;
  logic             act_reconv;
  logic             act_ret;
  logic [PC_W-1:0]  nxt_pc;
  logic             br_taken;
  logic             misalign;

  zbr_decode #(
    .INSN_W (INSN_W),
    .OFF_W  (OFF_W)
  ) u_decode (
    .insn_i   (insn_i),
    .kind_o   (kind),
    .pol_o    (pol),
    .offset_o (offset),
    .reconv_o (act_reconv),
    .ret_o    (act_ret)
  );

  zbr_target #(
    .PC_W  (PC_W),
    .SRC_W (SRC_W),
    .OFF_W (OFF_W)
  ) u_target (
    .cur_pc_i   (cur_pc_i),
    .src_i      (src_i),
    .ind_tgt_i  (ind_tgt_i),
    .kind_i     (kind),
    .pol_i      (pol),
    .offset_i   (offset),
    .nxt_pc_o   (nxt_pc),
    .taken_o    (br_taken),
    .misalign_o (misalign)
  );

  zbr_pc_reg #(
    .PC_W      (PC_W),
    .RESET_VEC (RESET_VEC)
  ) u_pc_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .cur_pc_i   (cur_pc_i),
    .nxt_pc_i   (nxt_pc),
    .taken_i    (br_taken),
    .misalign_i (misalign),
    .reconv_i   (act_reconv),
    .ret_i      (act_ret),
    .pc_o       (next_pc_o),
    .taken_o    (taken_o),
    .reconv_o   (reconv_o),
    .halt_o     (halt_o),
    .fault_o    (align_fault_o)
  );

endmodule

// File: rtl/zbr_pc_checker.sv
`timescale 1ns/1ps
module zbr_pc_checker #(
  parameter int PC_W   = 64,
  parameter int INSN_W = 64,
  parameter int SRC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [PC_W-1:0]   cur_pc_i,
  input logic [INSN_W-1:0] insn_i,
  input logic [SRC_W-1:0]  src_i,
  input logic [PC_W-1:0]   ind_tgt_i,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              taken_o,
  input logic              reconv_o,
  input logic              halt_o,
  input logic              align_fault_o
);

  logic       accept;
  logic       is_dir;
  logic       is_ind;
  logic       is_ret;
  logic       is_rcv;

  assign accept = valid_i && !halt_o;
  assign is_dir = (insn_i[7:0] == 8'h1F);
  assign is_ind = (insn_i[7:0] == 8'h2F);
  assign is_ret = (insn_i[61:59] == 3'd7);
  assign is_rcv = (insn_i[61:59] == 3'd2);

  p_seq_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_dir && !is_ind && !is_ret) |=>
      (next_pc_o == $past(cur_pc_i) + 64'd8) && !taken_o);

  p_zero_src_pol0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (is_dir || is_ind) && !is_ret && !insn_i[36] && (src_i == '0)) |=>
      !taken_o && (next_pc_o == $past(cur_pc_i) + 64'd8));

  p_misalign_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_ind && !is_ret && insn_i[36] && (src_i == '0) && (ind_tgt_i[2:0] != 3'd0)) |=>
      align_fault_o && (next_pc_o[2:0] == 3'd0));

  p_fault_needs_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault_o |-> taken_o);

  p_reconv_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_rcv) |=> reconv_o);

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o && $stable(next_pc_o));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(next_pc_o) && $stable(taken_o) && $stable(align_fault_o));

endmodule

bind zbr_pc_unit zbr_pc_checker #(
  .PC_W   (PC_W),
  .INSN_W (INSN_W),
  .SRC_W  (SRC_W)
) u_chk (.*);

// File: tb/zbr_pc_unit_bench.sv
`timescale 1ns/1ps
module zbr_pc_unit_bench;

  localparam logic [63:0] RST_VEC = 64'h1000;

  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [63:0] cur_pc_i;
  logic [63:0] insn_i;
  logic [31:0] src_i;
  logic [63:0] ind_tgt_i;
  logic [63:0] next_pc_o;
  logic        taken_o;
  logic        reconv_o;
  logic        halt_o;
  logic        align_fault_o;

  int checks;
  int failures;

  zbr_pc_unit u_zbr_pc_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .valid_i       (valid_i),
    .cur_pc_i      (cur_pc_i),
    .insn_i        (insn_i),
    .src_i         (src_i),
    .ind_tgt_i     (ind_tgt_i),
    .next_pc_o     (next_pc_o),
    .taken_o       (taken_o),
    .reconv_o      (reconv_o),
    .halt_o        (halt_o),
    .align_fault_o (align_fault_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] mk(input logic [7:0] opc, input logic [26:0] off,
                                     input logic pol, input logic [2:0] act);
    logic [63:0] w;
    w = '0;
    w[7:0]   = opc;
    w[34:8]  = off;
    w[36]    = pol;
    w[61:59] = act;
    return w;
  endfunction

  function automatic logic [63:0] dir_exp(input logic [63:0] pc, input logic [26:0] off);
    longint signed so;
    so = longint'($signed(off));
    return pc + 64'((so + 1) * 8);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic issue(input logic [63:0] pc, input logic [63:0] w, input logic [31:0] s,
                       input logic [63:0] t);
    cur_pc_i  = pc;
    insn_i    = w;
    src_i     = s;
    ind_tgt_i = t;
    valid_i   = 1'b1;
    @(negedge clk);
    valid_i   = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "pc", next_pc_o, RST_VEC);
    chk("R1", "flags", {60'd0, taken_o, reconv_o, halt_o, align_fault_o}, 64'd0);
  endtask

  task automatic t_seq();
    issue(64'h2000, mk(8'h00, 27'd9, 1'b0, 3'd0), 32'd1, 64'h0);
    chk("R2", "nop pc", next_pc_o, 64'h2008);
    chk("R2", "nop taken", {63'd0, taken_o}, 64'd0);
    issue(64'h3000, mk(8'h45, 27'h7FF, 1'b1, 3'd0), 32'd0, 64'h0);
    chk("R2", "other opc pc", next_pc_o, 64'h3008);
    issue(64'h3100, mk(8'h1E, 27'd4, 1'b0, 3'd0), 32'd5, 64'h0);
    chk("R2", "near opc pc", next_pc_o, 64'h3108);
  endtask

  task automatic t_direct();
    logic [63:0] pc;
    pc = 64'h1_0000_0000;
    issue(pc, mk(8'h1F, 27'd5, 1'b0, 3'd0), 32'd7, 64'h0);
    chk("R3", "off +5", next_pc_o, dir_exp(pc, 27'd5));
    chk("R3", "taken", {63'd0, taken_o}, 64'd1);
    issue(pc, mk(8'h1F, 27'd0, 1'b0, 3'd0), 32'd7, 64'h0);
    chk("R3", "off 0", next_pc_o, pc + 64'd8);
    issue(pc, mk(8'h1F, 27'h7FFFFFD, 1'b0, 3'd0), 32'd7, 64'h0);
    chk("R3", "off -3", next_pc_o, pc - 64'd16);
    issue(pc, mk(8'h1F, 27'h3FFFFFF, 1'b0, 3'd0), 32'd1, 64'h0);
    chk("R3", "off max", next_pc_o, pc + 64'h2000_0000);
    issue(pc, mk(8'h1F, 27'h4000000, 1'b0, 3'd0), 32'd1, 64'h0);
    chk("R3", "off min", next_pc_o, pc - 64'h1FFF_FFF8);
  endtask

  task automatic t_polarity();
    issue(64'h5000, mk(8'h1F, 27'd3, 1'b0, 3'd0), 32'd0, 64'h0);
    chk("R4", "pol0 zero pc", next_pc_o, 64'h5008);
    chk("R4", "pol0 zero taken", {63'd0, taken_o}, 64'd0);
    issue(64'h5000, mk(8'h1F, 27'd3, 1'b1, 3'd0), 32'd0, 64'h0);
    chk("R4", "pol1 zero pc", next_pc_o, 64'h5020);
    chk("R4", "pol1 zero taken", {63'd0, taken_o}, 64'd1);
    issue(64'h5000, mk(8'h1F, 27'd3, 1'b1, 3'd0), 32'h8000_0000, 64'h0);
    chk("R4", "pol1 nonzero pc", next_pc_o, 64'h5008);
    issue(64'h5000, mk(8'h2F, 27'd0, 1'b0, 3'd0), 32'd0, 64'h9000);
    chk("R4", "ind pol0 zero pc", next_pc_o, 64'h5008);
  endtask

  task automatic t_indirect();
    issue(64'h6000, mk(8'h2F, 27'd0, 1'b0, 3'd0), 32'd2, 64'hABCD_0000_0000_1238);
    chk("R5", "aligned tgt", next_pc_o, 64'hABCD_0000_0000_1238);
    chk("R6", "no fault aligned", {63'd0, align_fault_o}, 64'd0);
    issue(64'h6000, mk(8'h2F, 27'd0, 1'b1, 3'd0), 32'd0, 64'h7777);
    chk("R5", "pol1 rounded tgt", next_pc_o, 64'h7770);
    chk("R6", "fault misaligned", {63'd0, align_fault_o}, 64'd1);
    issue(64'h6000, mk(8'h2F, 27'd0, 1'b1, 3'd0), 32'd4, 64'h7777);
    chk("R6", "no fault not taken", {63'd0, align_fault_o}, 64'd0);
    chk("R5", "not taken pc", next_pc_o, 64'h6008);
  endtask

  task automatic t_action();
    issue(64'h8000, mk(8'h1F, 27'd1, 1'b0, 3'd2), 32'd1, 64'h0);
    chk("R7", "reconv set", {63'd0, reconv_o}, 64'd1);
    chk("R7", "reconv pc", next_pc_o, 64'h8010);
    issue(64'h8000, mk(8'h1F, 27'd1, 1'b0, 3'd0), 32'd1, 64'h0);
    chk("R10", "wait action pc", next_pc_o, 64'h8010);
    chk("R7", "reconv clear", {63'd0, reconv_o}, 64'd0);
    issue(64'h8100, mk(8'h00, 27'd1, 1'b0, 3'd1), 32'd1, 64'h0);
    chk("R10", "barrier action pc", next_pc_o, 64'h8108);
    issue(64'h8200, mk(8'h2F, 27'd0, 1'b0, 3'd5), 32'd1, 64'h4440);
    chk("R10", "kill action pc", next_pc_o, 64'h4440);
    chk("R7", "reconv code5", {63'd0, reconv_o}, 64'd0);
  endtask

  task automatic t_idle();
    logic [63:0] held;
    issue(64'hA000, mk(8'h2F, 27'd0, 1'b1, 3'd2), 32'd0, 64'hB003);
    held = next_pc_o;
    cur_pc_i  = 64'hFFF0;
    insn_i    = mk(8'h1F, 27'd100, 1'b0, 3'd7);
    src_i     = 32'd1;
    ind_tgt_i = 64'h1;
    repeat (3) @(negedge clk);
    chk("R9", "idle pc", next_pc_o, held);
    chk("R9", "idle flags", {60'd0, taken_o, reconv_o, halt_o, align_fault_o}, 64'hD);
  endtask

  task automatic t_return();
    issue(64'hC000, mk(8'h1F, 27'd10, 1'b0, 3'd7), 32'd1, 64'h0);
    chk("R8", "halt set", {63'd0, halt_o}, 64'd1);
    chk("R8", "pc held at return", next_pc_o, 64'hC000);
    chk("R8", "taken clear", {63'd0, taken_o}, 64'd0);
    issue(64'hD000, mk(8'h1F, 27'd2, 1'b0, 3'd2), 32'd1, 64'h0);
    chk("R8", "pc frozen", next_pc_o, 64'hC000);
    chk("R8", "reconv frozen", {63'd0, reconv_o}, 64'd0);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    valid_i = 1'b0;
    cur_pc_i = '0;
    insn_i = '0;
    src_i = '0;
    ind_tgt_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_direct();
    t_polarity();
    t_indirect();
    t_action();
    t_idle();
    t_return();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule